// File: doc/BRIEF.md
# Auto Channel Gating Combiner

This block merges the demodulated data bits of several receive channels (three by default) into one data line. With the gating feature switched off, every channel passes and the output is the OR of all synchronised channel levels. With the feature switched on, the block waits for a one-cycle settling-done pulse. At that pulse it captures each channel's current level. Channels that were high are kept and channels that were low are masked. The mask then holds until the next soft reset, so only channels that carried a valid signal at the end of the settling window can add noise to the merged data line.

The channel inputs are asynchronous. Each one passes through a synchroniser chain before it is sampled or combined. A status vector reports which channels are currently passing. The carrier-clock bypass path goes straight through and is never gated.

The control is a three-state machine. `GS_BYPASS`: the feature is off and everything passes. `GS_WAIT`: the feature is on, no capture has happened yet, and everything passes. `GS_LOCKED`: the mask holds the captured levels. The named transitions are:
- `T_ARM` (BYPASS→WAIT when enable is high);
- `T_CAPTURE` (WAIT→LOCKED on a settling pulse);
- `T_DISARM` (WAIT or LOCKED→BYPASS when enable is low);
- `T_SOFT` (any state→WAIT, or →BYPASS if enable is low, on soft reset).

Top module: `auto_chan_gate`

## Requirements
- R1: While `gate_en` is low, the next clock edge forces `pass_status` to all ones, and every channel then contributes to `data_out`.
- R2: With `gate_en` high in the waiting state, a `settle_done` pulse loads `pass_status` at that edge with the synchronised channel levels, where a 1 means pass.
- R3: Bit i of `pass_status` reports channel i, which is bit i of `ch_data`.
- R4: `data_out` is the OR of the synchronised channels whose `pass_status` bit is 1. A change on `ch_data` reaches `data_out` after two rising clock edges.
- R5: A `soft_rst` pulse sets `pass_status` to all ones at the next edge. It has priority over a `settle_done` pulse in the same cycle.
- R6: After `rst_n` and before the first capture, `pass_status` is all ones.
- R7: A `settle_done` pulse while the mask is locked does not change `pass_status`.
- R8: `carrier_out` follows `carrier_in` without gating, in any state.
- R9: A `settle_done` pulse in the cycle where `gate_en` first rises from the bypass state is ignored. Dropping `gate_en` and raising it again after a capture returns to waiting with all channels passing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | Switches channel gating on |
| settle_done | input | 1 | One-cycle pulse at the end of the settling window |
| soft_rst | input | 1 | Synchronous soft reset that clears all gating |
| ch_data | input | NUM_CH | Asynchronous demodulated channel bits |
| carrier_in | input | 1 | Carrier-clock bypass input |
| data_out | output | 1 | Merged gated data |
| carrier_out | output | 1 | Ungated carrier-clock bypass output |
| pass_status | output | NUM_CH | Per-channel pass (1) or block (0) state |

## Verification
The hardest situations to reach are the ones where two control events land on the same clock edge. One is a soft reset together with a settling pulse. The other is a settling pulse in the very cycle that enable rises. Each is only meaningful if the channel levels have already settled through the synchroniser. The directed stimulus holds each channel pattern for several cycles before it fires these coincident pulses. A random phase then mixes enable, soft reset and pulses, and a behavioural model in the bench is compared against the design on every cycle.

// File: rtl/acg_pkg.sv
package acg_pkg;
    typedef enum logic [1:0] {
        GS_BYPASS = 2'd0,
        GS_WAIT   = 2'd1,
        GS_LOCKED = 2'd2
    } gate_state_e;
endpackage

// File: rtl/acg_sync.sv
module acg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [DEPTH-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[DEPTH-2:0], async_in[b]};
            end
        end
        assign sync_out[b] = chain_q[DEPTH-1];
    end
endmodule

// File: rtl/acg_fsm.sv
module acg_fsm
    import acg_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en,
    input  logic              settle_done,
    input  logic              soft_rst,
    input  logic [NUM_CH-1:0] ch_sync,
    output gate_state_e       state_q,
    output logic [NUM_CH-1:0] mask_q
);
    localparam logic [NUM_CH-1:0] ALL_PASS = {NUM_CH{1'b1}};

    gate_state_e state_d;
    logic        capture;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        if (soft_rst) begin
            // T_SOFT
            state_d = gate_en ? GS_WAIT : GS_BYPASS;
        end else begin
            unique case (state_q)
                GS_BYPASS: begin
                    if (gate_en) state_d = GS_WAIT;          // T_ARM
                end
                GS_WAIT: begin
                    if (!gate_en) begin
                        state_d = GS_BYPASS;                 // T_DISARM
                    end else if (settle_done) begin
                        state_d = GS_LOCKED;                 // T_CAPTURE
                        capture = 1'b1;
                    end
                end
                GS_LOCKED: begin
                    if (!gate_en) state_d = GS_BYPASS;       // T_DISARM
                end
                default: state_d = GS_BYPASS;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_BYPASS;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: pass mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= ALL_PASS;
        end else if (capture) begin
            mask_q <= ch_sync;
        end else if (state_d != GS_LOCKED) begin
            mask_q <= ALL_PASS;
        end
    end
endmodule

// File: rtl/acg_merge.sv
module acg_merge #(
    parameter int NUM_CH = 3
) (
    input  logic [NUM_CH-1:0] ch_sync,
    input  logic [NUM_CH-1:0] mask,
    output logic              merged
);
    logic [NUM_CH-1:0] gated;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_gate
        assign gated[c] = ch_sync[c] & mask[c];
    end

    assign merged = |gated;
endmodule

// File: rtl/auto_chan_gate.sv
module auto_chan_gate
    import acg_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en,
    input  logic              settle_done,
    input  logic              soft_rst,
    input  logic [NUM_CH-1:0] ch_data,
    input  logic              carrier_in,
    output logic              data_out,
    output logic              carrier_out,
    output logic [NUM_CH-1:0] pass_status
);
    logic [NUM_CH-1:0] ch_sync;
    logic [NUM_CH-1:0] mask;
    gate_state_e       state_q;

    acg_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ch_data),
        .sync_out (ch_sync)
    );

    acg_fsm #(
        .NUM_CH (NUM_CH)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_en     (gate_en),
        .settle_done (settle_done),
        .soft_rst    (soft_rst),
        .ch_sync     (ch_sync),
        .state_q     (state_q),
        .mask_q      (mask)
    );

    acg_merge #(
        .NUM_CH (NUM_CH)
    ) u_merge (
        .ch_sync (ch_sync),
        .mask    (mask),
        .merged  (data_out)
    );

    assign pass_status = mask;
    assign carrier_out = carrier_in;
endmodule

// File: rtl/acg_checker.sv
module acg_checker
    import acg_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gate_en,
    input logic              settle_done,
    input logic              soft_rst,
    input logic [NUM_CH-1:0] ch_sync,
    input gate_state_e       state_q,
    input logic [NUM_CH-1:0] pass_status,
    input logic              data_out
);
    AST_DISABLED_ALL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> pass_status == {NUM_CH{1'b1}});                       // R1

    AST_CAPTURE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_WAIT && gate_en && settle_done && !soft_rst)
        |=> pass_status == $past(ch_sync));                                // R2

    AST_BLOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_status == '0) |-> !data_out);                                // R4

    AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> pass_status == {NUM_CH{1'b1}});                       // R5

    AST_OPEN_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != GS_LOCKED) |-> pass_status == {NUM_CH{1'b1}});         // R6

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_LOCKED && gate_en && !soft_rst) |=> $stable(pass_status)); // R7

    AST_ARM_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_BYPASS && !soft_rst) |=> state_q != GS_LOCKED);     // R9
endmodule

bind auto_chan_gate acg_checker #(
    .NUM_CH (NUM_CH)
) u_acg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_en     (gate_en),
    .settle_done (settle_done),
    .soft_rst    (soft_rst),
    .ch_sync     (ch_sync),
    .state_q     (state_q),
    .pass_status (pass_status),
    .data_out    (data_out)
);

// File: tb/auto_chan_gate_bench.sv
`timescale 1ns/1ps
module auto_chan_gate_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate_en = 1'b0;
    logic       settle_done = 1'b0;
    logic       soft_rst = 1'b0;
    logic [2:0] ch_data = 3'b000;
    logic       carrier_in = 1'b0;
    logic       data_out;
    logic       carrier_out;
    logic [2:0] pass_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    auto_chan_gate u_auto_chan_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_en     (gate_en),
        .settle_done (settle_done),
        .soft_rst    (soft_rst),
        .ch_data     (ch_data),
        .carrier_in  (carrier_in),
        .data_out    (data_out),
        .carrier_out (carrier_out),
        .pass_status (pass_status)
    );

    // Behavioural reference: delay queue for inputs, integer mode
    int       m_mode;           // 0 off, 1 waiting, 2 holding
    bit [2:0] m_pipe[$];
    bit [2:0] m_mask;

    function automatic bit [2:0] m_seen();
        return m_pipe[0];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0;
            m_mask = 3'b111;
            m_pipe = '{3'b000, 3'b000};
        end else begin
            if (soft_rst) begin
                m_mode = gate_en ? 1 : 0;
                m_mask = 3'b111;
            end else if (!gate_en) begin
                m_mode = 0;
                m_mask = 3'b111;
            end else if (m_mode == 0) begin
                m_mode = 1;
            end else if (m_mode == 1 && settle_done) begin
                m_mode = 2;
                m_mask = m_seen();
            end
            void'(m_pipe.pop_front());
            m_pipe.push_back(ch_data);
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R3 pass_status vs model", pass_status, m_mask);
            check("R4 data_out vs model", data_out, |(m_seen() & m_mask));
            check("R8 carrier_out", carrier_out, carrier_in);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_settle();
        settle_done = 1'b1;
        step(1);
        settle_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    always @(negedge clk) carrier_in <= ~carrier_in;

    initial begin
        step(2);
        check("R6 status in reset", pass_status, 3'b111);
        rst_n = 1'b1;
        step(2);
        check("R6 status after reset", pass_status, 3'b111);
        check("R4 data idle", data_out, 0);

        gate_en = 1'b1;
        ch_data = 3'b101;
        step(3);
        check("R6 open before capture", pass_status, 3'b111);
        check("R4 data all pass", data_out, 1);

        pulse_settle();
        check("R2 captured levels", pass_status, 3'b101);
        check("R3 bit order ch0", pass_status[0], 1);

        ch_data = 3'b010;
        step(1);
        check("R4 two-edge latency old value", data_out, 1);
        step(1);
        check("R4 masked channel silent", data_out, 0);
        ch_data = 3'b011;
        step(2);
        check("R4 passing channel heard", data_out, 1);

        ch_data = 3'b111;
        step(3);
        pulse_settle();
        check("R7 second pulse ignored", pass_status, 3'b101);

        soft_rst = 1'b1;
        step(1);
        soft_rst = 1'b0;
        check("R5 soft reset clears", pass_status, 3'b111);
        ch_data = 3'b000;
        step(3);
        pulse_settle();
        check("R2 all blocked", pass_status, 3'b000);
        ch_data = 3'b111;
        step(3);
        check("R4 all blocked silent", data_out, 0);

        soft_rst = 1'b1;
        settle_done = 1'b1;
        ch_data = 3'b110;
        step(1);
        soft_rst = 1'b0;
        settle_done = 1'b0;
        check("R5 soft beats pulse", pass_status, 3'b111);

        gate_en = 1'b0;
        step(1);
        check("R1 disabled all pass", pass_status, 3'b111);
        ch_data = 3'b001;
        step(3);
        check("R1 disabled data passes", data_out, 1);

        gate_en = 1'b1;
        settle_done = 1'b1;
        step(1);
        settle_done = 1'b0;
        check("R9 pulse on arming ignored", pass_status, 3'b111);
        pulse_settle();
        check("R9 next pulse captures", pass_status, 3'b001);
        gate_en = 1'b0;
        step(1);
        gate_en = 1'b1;
        step(1);
        check("R9 rearm waits open", pass_status, 3'b111);

        for (int i = 0; i < 400; i++) begin
            ch_data     = 3'($urandom);
            gate_en     = ($urandom % 8) != 0;
            settle_done = ($urandom % 6) == 0;
            soft_rst    = ($urandom % 20) == 0;
            step(1);
        end
        settle_done = 1'b0;
        soft_rst = 1'b0;
        step(2);
        finish_run();
    end
endmodule